// File: doc/BRIEF.md
# Bit-Manipulation Execute Unit

This unit computes one bit-manipulation result per cycle on 64-bit integer operands. An operation code, two 64-bit sources and a 6-bit amount are presented together with a valid strobe. The result is produced by combinational logic and captured in an output register, so it appears one clock later.

The unit covers several groups of operations:
- scaled-index address adds, including forms that first zero-extend the low word;
- single-bit set, clear, invert and extract;
- leading-zero, trailing-zero and population counts over the low word;
- word rotates;
- operand packing;
- byte reversal;
- ones-filling shifts.

Operation codes outside the defined set return zero and raise an illegal flag. Decoding of instructions into operation codes happens upstream of this unit.

Top module: `bmu_alu`

## Requirements
- R1: After reset `result_o`, `illegal_o` and `valid_o` are zero. A cycle with `valid_i` high loads the result register at that clock edge, and `valid_o` is high in the following cycle.
- R2: While `valid_i` is low, `result_o` and `illegal_o` keep their values whatever the other inputs do, and `valid_o` is low.
- R3: Codes 0, 1 and 2 return (`src_a_i` shifted left by 1, 2 or 3) plus `src_b_i`, modulo 2^64.
- R4: Codes 3, 4, 5 and 6 first zero-extend the low 32 bits of `src_a_i`. They then shift that value left by 0, 1, 2 or 3 and add `src_b_i`.
- R5: Codes 7, 8, 9 and 10 use `amt_i` (0..63) as a bit index. Code 7 sets that bit of `src_a_i`, code 8 clears it and code 9 inverts it. Code 10 returns that bit in bit 0, with all other bits zero.
- R6: Code 11 returns the number of leading zeros in `src_a_i[31:0]`, and 32 when that word is zero. The upper 32 bits have no effect.
- R7: Code 12 returns the number of trailing zeros in `src_a_i[31:0]`, and 32 when that word is zero, whatever the upper bits hold.
- R8: Code 13 returns the number of set bits in `src_a_i[31:0]` only.
- R9: Code 14 rotates `src_a_i[31:0]` left and code 15 rotates it right, by `amt_i[4:0]`. The 32-bit result is sign-extended to 64 bits.
- R10: Code 16 returns {`src_b_i[31:0]`, `src_a_i[31:0]`}. Code 17 returns {`src_b_i[63:32]`, `src_a_i[63:32]`}. Code 18 returns {48 zeros, `src_b_i[7:0]`, `src_a_i[7:0]`}.
- R11: Code 19 returns `src_a_i` with its eight bytes in reverse order.
- R12: Code 20 shifts `src_a_i` left and code 21 shifts it right, by `amt_i` (0..63). In both, the vacated positions are filled with ones.
- R13: Codes 22 to 31 load zero into `result_o` and set `illegal_o`. Any defined code clears `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| src_a_i | input | 64 | First source |
| src_b_i | input | 64 | Second source |
| amt_i | input | 6 | Shift, rotate or bit-index amount |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered: last operation had an undefined code |
| valid_o | output | 1 | Result register was loaded at the last edge |

## Verification
Undefined-code detection and the hold-while-idle behaviour both act on the same result register in the same cycle.

The bench presents an undefined code with `valid_i` low, right after a legal result. It judges that both the result and the clear illegal flag survive unchanged. It then presents the same code with `valid_i` high and expects zero with the flag set. A following legal operation must clear the flag in the same edge that loads the new result.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [4:0] {
    OP_SH1ADD    = 5'd0,
    OP_SH2ADD    = 5'd1,
    OP_SH3ADD    = 5'd2,
    OP_ADD_UW    = 5'd3,
    OP_SH1ADD_UW = 5'd4,
    OP_SH2ADD_UW = 5'd5,
    OP_SH3ADD_UW = 5'd6,
    OP_BSET      = 5'd7,
    OP_BCLR      = 5'd8,
    OP_BINV      = 5'd9,
    OP_BEXT      = 5'd10,
    OP_CLZW      = 5'd11,
    OP_CTZW      = 5'd12,
    OP_CPOPW     = 5'd13,
    OP_ROLW      = 5'd14,
    OP_RORW      = 5'd15,
    OP_PACK      = 5'd16,
    OP_PACKU     = 5'd17,
    OP_PACKH     = 5'd18,
    OP_REV8      = 5'd19,
    OP_SLO       = 5'd20,
    OP_SRO       = 5'd21
  } bmu_op_e;

  typedef enum logic [1:0] {
    UNIT_ADD  = 2'd0,
    UNIT_BIT  = 2'd1,
    UNIT_CNT  = 2'd2,
    UNIT_PERM = 2'd3
  } bmu_unit_e;

  typedef enum logic [1:0] {
    BIT_SET = 2'd0,
    BIT_CLR = 2'd1,
    BIT_INV = 2'd2,
    BIT_EXT = 2'd3
  } bit_kind_e;

  typedef enum logic [1:0] {
    CNT_CLZ = 2'd0,
    CNT_CTZ = 2'd1,
    CNT_POP = 2'd2
  } cnt_kind_e;

  typedef enum logic [2:0] {
    PERM_ROL   = 3'd0,
    PERM_ROR   = 3'd1,
    PERM_PACK  = 3'd2,
    PERM_PACKU = 3'd3,
    PERM_PACKH = 3'd4,
    PERM_REV8  = 3'd5,
    PERM_SLO   = 3'd6,
    PERM_SRO   = 3'd7
  } perm_kind_e;

  typedef struct packed {
    logic       legal;
    bmu_unit_e  unit;
    logic [1:0] scale;
    logic       uw;
    bit_kind_e  bit_kind;
    cnt_kind_e  cnt_kind;
    perm_kind_e perm_kind;
  } bmu_ctl_t;
endpackage

// File: rtl/bmu_addgen.sv
module bmu_addgen #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      scale_i,
  input  logic            uw_i,
  output logic [XLEN-1:0] sum_o
);
  localparam int W = XLEN / 2;

  logic [XLEN-1:0] base;

  always_comb begin
    base  = uw_i ? {{(XLEN-W){1'b0}}, a_i[W-1:0]} : a_i;
    sum_o = (base << scale_i) + b_i;
  end
endmodule

// File: rtl/bmu_bitop.sv
module bmu_bitop #(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [IDX_W-1:0] idx_i,
  input  bmu_pkg::bit_kind_e kind_i,
  output logic [XLEN-1:0]  res_o
);
  import bmu_pkg::*;

  logic [XLEN-1:0] mask;

  always_comb begin
    mask = {{(XLEN-1){1'b0}}, 1'b1} << idx_i;
    unique case (kind_i)
      BIT_SET: res_o = a_i | mask;
      BIT_CLR: res_o = a_i & ~mask;
      BIT_INV: res_o = a_i ^ mask;
      default: res_o = {{(XLEN-1){1'b0}}, |(a_i & mask)};
    endcase
  end
endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 64,
  parameter int W    = XLEN / 2
) (
  input  logic [W-1:0]     w_i,
  input  bmu_pkg::cnt_kind_e kind_i,
  output logic [XLEN-1:0]  res_o
);
  import bmu_pkg::*;

  localparam int CW = $clog2(W) + 1;

  logic [CW-1:0] lead, trail, pop;
  logic          hit_l, hit_t;

  always_comb begin
    lead  = CW'(W);
    hit_l = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit_l && w_i[i]) begin
        lead  = CW'(W - 1 - i);
        hit_l = 1'b1;
      end
    end
  end

  always_comb begin
    trail = CW'(W);
    hit_t = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!hit_t && w_i[i]) begin
        trail = CW'(i);
        hit_t = 1'b1;
      end
    end
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + CW'(w_i[i]);
  end

  always_comb begin
    unique case (kind_i)
      CNT_CLZ: res_o = {{(XLEN-CW){1'b0}}, lead};
      CNT_CTZ: res_o = {{(XLEN-CW){1'b0}}, trail};
      default: res_o = {{(XLEN-CW){1'b0}}, pop};
    endcase
  end
endmodule

// File: rtl/bmu_permute.sv
module bmu_permute #(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IDX_W-1:0] amt_i,
  input  bmu_pkg::perm_kind_e kind_i,
  output logic [XLEN-1:0]  res_o
);
  import bmu_pkg::*;

  localparam int W      = XLEN / 2;
  localparam int RW     = $clog2(W);
  localparam int NBYTES = XLEN / 8;

  logic [W-1:0]      word;
  logic [2*W-1:0]    dbl_l, dbl_r;
  logic [W-1:0]      rot;
  logic [XLEN-1:0]   rev;

  assign word  = a_i[W-1:0];
  assign dbl_l = {word, word} << amt_i[RW-1:0];
  assign dbl_r = {word, word} >> amt_i[RW-1:0];
  assign rot   = (kind_i == PERM_ROL) ? dbl_l[2*W-1:W] : dbl_r[W-1:0];

  for (genvar k = 0; k < NBYTES; k++) begin : g_rev
    assign rev[8*k +: 8] = a_i[XLEN-8-8*k +: 8];
  end

  always_comb begin
    unique case (kind_i)
      PERM_ROL,
      PERM_ROR:   res_o = {{(XLEN-W){rot[W-1]}}, rot};
      PERM_PACK:  res_o = {b_i[W-1:0], a_i[W-1:0]};
      PERM_PACKU: res_o = {b_i[XLEN-1:W], a_i[XLEN-1:W]};
      PERM_PACKH: res_o = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
      PERM_REV8:  res_o = rev;
      PERM_SLO:   res_o = ~((~a_i) << amt_i);
      default:    res_o = ~((~a_i) >> amt_i);
    endcase
  end
endmodule

// File: rtl/bmu_alu.sv
module bmu_alu #(
  parameter int XLEN = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [4:0]               op_i,
  input  logic [XLEN-1:0]          src_a_i,
  input  logic [XLEN-1:0]          src_b_i,
  input  logic [$clog2(XLEN)-1:0]  amt_i,
  output logic [XLEN-1:0]          result_o,
  output logic                     illegal_o,
  output logic                     valid_o
);
  import bmu_pkg::*;

  localparam int IDX_W = $clog2(XLEN);
  localparam int W     = XLEN / 2;

  bmu_ctl_t        ctl;
  logic [XLEN-1:0] add_res, bit_res, cnt_res, perm_res, nxt_res;

  always_comb begin
    ctl           = '0;
    ctl.legal     = 1'b1;
    ctl.unit      = UNIT_ADD;
    ctl.bit_kind  = BIT_SET;
    ctl.cnt_kind  = CNT_CLZ;
    ctl.perm_kind = PERM_ROL;
    unique case (op_i)
      OP_SH1ADD:    ctl.scale = 2'd1;
      OP_SH2ADD:    ctl.scale = 2'd2;
      OP_SH3ADD:    ctl.scale = 2'd3;
      OP_ADD_UW:    ctl.uw    = 1'b1;
      OP_SH1ADD_UW: begin ctl.uw = 1'b1; ctl.scale = 2'd1; end
      OP_SH2ADD_UW: begin ctl.uw = 1'b1; ctl.scale = 2'd2; end
      OP_SH3ADD_UW: begin ctl.uw = 1'b1; ctl.scale = 2'd3; end
      OP_BSET:  begin ctl.unit = UNIT_BIT;  ctl.bit_kind  = BIT_SET;    end
      OP_BCLR:  begin ctl.unit = UNIT_BIT;  ctl.bit_kind  = BIT_CLR;    end
      OP_BINV:  begin ctl.unit = UNIT_BIT;  ctl.bit_kind  = BIT_INV;    end
      OP_BEXT:  begin ctl.unit = UNIT_BIT;  ctl.bit_kind  = BIT_EXT;    end
      OP_CLZW:  begin ctl.unit = UNIT_CNT;  ctl.cnt_kind  = CNT_CLZ;    end
      OP_CTZW:  begin ctl.unit = UNIT_CNT;  ctl.cnt_kind  = CNT_CTZ;    end
      OP_CPOPW: begin ctl.unit = UNIT_CNT;  ctl.cnt_kind  = CNT_POP;    end
      OP_ROLW:  begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_ROL;   end
      OP_RORW:  begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_ROR;   end
      OP_PACK:  begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_PACK;  end
      OP_PACKU: begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_PACKU; end
      OP_PACKH: begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_PACKH; end
      OP_REV8:  begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_REV8;  end
      OP_SLO:   begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_SLO;   end
      OP_SRO:   begin ctl.unit = UNIT_PERM; ctl.perm_kind = PERM_SRO;   end
      default:  ctl.legal = 1'b0;
    endcase
  end

  bmu_addgen #(.XLEN(XLEN)) u_add (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .scale_i(ctl.scale),
    .uw_i   (ctl.uw),
    .sum_o  (add_res)
  );

  bmu_bitop #(.XLEN(XLEN), .IDX_W(IDX_W)) u_bit (
    .a_i   (src_a_i),
    .idx_i (amt_i),
    .kind_i(ctl.bit_kind),
    .res_o (bit_res)
  );

  bmu_count #(.XLEN(XLEN), .W(W)) u_cnt (
    .w_i   (src_a_i[W-1:0]),
    .kind_i(ctl.cnt_kind),
    .res_o (cnt_res)
  );

  bmu_permute #(.XLEN(XLEN), .IDX_W(IDX_W)) u_perm (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .amt_i (amt_i),
    .kind_i(ctl.perm_kind),
    .res_o (perm_res)
  );

  always_comb begin
    unique case (ctl.unit)
      UNIT_ADD: nxt_res = add_res;
      UNIT_BIT: nxt_res = bit_res;
      UNIT_CNT: nxt_res = cnt_res;
      default:  nxt_res = perm_res;
    endcase
    if (!ctl.legal) nxt_res = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt_res;
        illegal_o <= ~ctl.legal;
      end
    end
  end
endmodule

// File: rtl/bmu_alu_chk.sv
module bmu_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic            valid_o
);
  import bmu_pkg::*;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o) && !valid_o)); // R2

  AST_EXT_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BEXT) |=> (result_o[XLEN-1:1] == '0)); // R5

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_CLZW || op_i == OP_CTZW || op_i == OP_CPOPW))
    |=> (result_o <= XLEN'(XLEN/2))); // R6

  AST_ROT_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_ROLW || op_i == OP_RORW))
    |=> (result_o[XLEN-1:XLEN/2] == {(XLEN/2){result_o[XLEN/2-1]}})); // R9

  AST_PACKH_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_PACKH) |=> (result_o[XLEN-1:16] == '0)); // R10

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0)); // R13

  AST_ILLEGAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > OP_SRO) |=> illegal_o); // R13
endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN)) u_bmu_alu_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .result_o (result_o),
  .illegal_o(illegal_o),
  .valid_o  (valid_o)
);

// File: tb/tb_bmu_alu.sv
module tb_bmu_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [5:0]  amt = '0;
  logic [63:0] res;
  logic        ill, vld;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  bmu_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .src_a_i(a), .src_b_i(b), .amt_i(amt),
    .result_o(res), .illegal_o(ill), .valid_o(vld)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [63:0] x, input logic [63:0] y,
                     input logic [5:0] s, input logic [63:0] exp, input string tag);
    @(negedge clk);
    valid = 1'b1; op = o; a = x; b = y; amt = s;
    @(posedge clk); #1;
    chk(tag, res, exp);
    chk({tag, " illegal"}, {63'd0, ill}, 64'd0);
    valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset result", res, 64'd0);
    chk("R1 reset flags", {62'd0, ill, vld}, 64'd0);
  endtask

  task automatic t_scaled_add;
    run(5'd0, 64'd5, 64'd7, 6'd0, 64'd17, "R3 sh1add");
    chk("R1 valid_o", {63'd0, vld}, 64'd1);
    run(5'd1, 64'd3, '1, 6'd0, 64'd11, "R3 sh2add wrap");
    run(5'd2, 64'h10, 64'd1, 6'd0, 64'h81, "R3 sh3add");
  endtask

  task automatic t_uw_add;
    run(5'd3, 64'hFFFFFFFF_00000002, 64'd1, 6'd0, 64'd3, "R4 add.uw");
    run(5'd5, 64'h12345678_80000000, 64'd0, 6'd0, 64'h2_00000000, "R4 sh2add.uw");
    run(5'd6, 64'hFFFFFFFF_FFFFFFFF, 64'd8, 6'd0, 64'h7_FFFFFFF8 + 64'd8, "R4 sh3add.uw");
  endtask

  task automatic t_bitops;
    run(5'd7, 64'd0, 64'd0, 6'd63, 64'h80000000_00000000, "R5 bset 63");
    run(5'd8, '1, 64'd0, 6'd0, 64'hFFFFFFFF_FFFFFFFE, "R5 bclr 0");
    run(5'd9, 64'hF0, 64'd0, 6'd4, 64'hE0, "R5 binv");
    run(5'd10, 64'h80000000_00000000, 64'd0, 6'd63, 64'd1, "R5 bext set");
    run(5'd10, 64'h7FFFFFFF_FFFFFFFF, 64'd0, 6'd63, 64'd0, "R5 bext clear");
  endtask

  task automatic t_counts;
    run(5'd11, 64'hFFFFFFFF_00000000, 64'd0, 6'd0, 64'd32, "R6 clzw zero word");
    run(5'd11, 64'h00000000_00010000, 64'd0, 6'd0, 64'd15, "R6 clzw");
    run(5'd11, 64'h00000000_80000000, 64'd0, 6'd0, 64'd0, "R6 clzw top bit");
    run(5'd12, 64'hFFFF0000_00000000, 64'd0, 6'd0, 64'd32, "R7 ctzw zero word");
    run(5'd12, 64'h100, 64'd0, 6'd0, 64'd8, "R7 ctzw");
    run(5'd13, 64'hFFFFFFFF_0000000F, 64'd0, 6'd0, 64'd4, "R8 cpopw");
    run(5'd13, 64'h00000000_FFFFFFFF, 64'd0, 6'd0, 64'd32, "R8 cpopw full");
  endtask

  task automatic t_rotates;
    run(5'd14, 64'h80000001, 64'd0, 6'd1, 64'd3, "R9 rolw wrap");
    run(5'd15, 64'h1, 64'd0, 6'd1, 64'hFFFFFFFF_80000000, "R9 rorw sext");
    run(5'd14, 64'h40000000, 64'd0, 6'd33, 64'hFFFFFFFF_80000000, "R9 rolw amt low5");
  endtask

  task automatic t_packs;
    run(5'd16, 64'hAAAAAAAA_11111111, 64'hBBBBBBBB_22222222, 6'd0, 64'h22222222_11111111, "R10 pack");
    run(5'd17, 64'hAAAAAAAA_11111111, 64'hBBBBBBBB_22222222, 6'd0, 64'hBBBBBBBB_AAAAAAAA, "R10 packu");
    run(5'd18, 64'hAAAAAAAA_11111111, 64'hBBBBBBBB_22222222, 6'd0, 64'h2211, "R10 packh");
  endtask

  task automatic t_rev_ones;
    run(5'd19, 64'h01020304_05060708, 64'd0, 6'd0, 64'h08070605_04030201, "R11 rev8");
    run(5'd20, 64'd0, 64'd0, 6'd4, 64'hF, "R12 slo");
    run(5'd21, 64'd0, 64'd0, 6'd8, 64'hFF000000_00000000, "R12 sro");
    run(5'd20, 64'd5, 64'd0, 6'd0, 64'd5, "R12 slo zero amount");
  endtask

  task automatic t_hold_illegal;
    run(5'd0, 64'd1, 64'd1, 6'd0, 64'd3, "R2 setup");
    @(negedge clk);
    valid = 1'b0; op = 5'd22; a = '1; b = '1;
    @(posedge clk); #1;
    chk("R2 hold result", res, 64'd3);
    chk("R2 hold flags", {62'd0, ill, vld}, 64'd0);
    @(negedge clk);
    valid = 1'b1; op = 5'd22;
    @(posedge clk); #1;
    chk("R13 illegal result", res, 64'd0);
    chk("R13 illegal flag", {63'd0, ill}, 64'd1);
    @(negedge clk);
    valid = 1'b1; op = 5'd31; a = 64'd9;
    @(posedge clk); #1;
    chk("R13 code 31", {res[62:0], ill}, 64'd1);
    valid = 1'b0;
    run(5'd9, 64'd0, 64'd0, 6'd2, 64'd4, "R13 legal clears");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_scaled_add();
    t_uw_add();
    t_bitops();
    t_counts();
    t_rotates();
    t_packs();
    t_rev_ones();
    t_hold_illegal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule